// File: doc/BRIEF.md
# One-Time-Programmable Protection Register

This block holds a 128-bit protection register for a non-volatile memory array. Software and test equipment see it as eight 16-bit words. Words 0 to 3 carry a factory identifier that is fixed by a parameter and loaded when reset is applied. No command can alter those words. Words 4 to 7 form a user segment. It starts erased (all ones) and can only be programmed downward: each program operation ANDs the supplied data into the stored word, so a bit can go from 1 to 0 but never back.

Two permanent lock bits sit beside the words. The user lock freezes the user segment against any further programming. The security lock protects array block 0. It drives the block-protection answer that the array's program/erase control asks for through a block index query. Neither lock can be cleared by any command or by reset. The user words and both locks keep their values across reset. Only the factory words are reloaded.

A command is presented for one cycle with `cmd_valid`, an opcode, a word address and write data. Exactly one cycle later the block reports the result on its status outputs, and on the read data output for a read.

Top module: `otp_prot_reg`

## Requirements
- R1: After reset, `op_done` and `op_err` are 0, `rd_data` is 0, and the factory words read back as FACTORY_ID, with word n equal to bits [16n+15:16n].
- R2: A read command (op code 0) of word n puts the stored word on `rd_data` one cycle later, with `op_done`=1 and `op_err`=0.
- R3: A program command (op code 1) to a user word (address 4 to 7) while the user lock is clear replaces the word with old AND data. No bit returns from 0 to 1, and `op_err` is 0.
- R4: A program command to a factory word (address 0 to 3) leaves every word unchanged and gives `op_err`=1 one cycle later.
- R5: A program command to a user word while the user lock is set leaves the word unchanged and gives `op_err`=1 one cycle later.
- R6: A lock-user command (op code 2) sets `user_locked` one cycle later with `op_err`=0. Once set, it stays set.
- R7: A lock-security command (op code 3) sets `sec_locked` one cycle later. Once set, it stays set. `blk_prot` equals `sec_locked` when `query_blk` is 0, and is 0 for any other block index.
- R8: Reset does not change the user words, `user_locked` or `sec_locked`.
- R9: `op_done` is 1 exactly in the cycle after each accepted command. `op_err` is never 1 without `op_done`.
- R10: Cycles without `cmd_valid` change no word and no lock, and leave `op_done` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 read, 1 program, 2 lock user segment, 3 lock security block |
| cmd_addr | input | 3 | Word address, 0-3 factory, 4-7 user |
| cmd_wdata | input | 16 | Program data (ANDed into the word) |
| query_blk | input | 7 | Array block index whose protection is asked |
| rd_data | output | 16 | Read result, valid with `op_done` after a read |
| op_done | output | 1 | Command completed (one cycle after acceptance) |
| op_err | output | 1 | Program was refused |
| user_locked | output | 1 | User segment permanently locked |
| sec_locked | output | 1 | Security block permanently locked |
| blk_prot | output | 1 | Queried block is protected by the security lock |

## Verification
Every command result (`op_done`, `op_err`, `rd_data`, the lock outputs) is registered. It is due at the first rising edge after the command is sampled. `blk_prot` follows `query_blk` in the same cycle. The bench drives each command on a falling edge, lets one rising edge pass, and samples on the next falling edge, which is where the registered result is due. It then reads the words back with separate read commands, so a refused or partial program is seen through the data it left behind.

// File: rtl/otp_pkg.sv
// Package: command codes shared by the protection-register modules.
// Assumes a 2-bit opcode field on the command port.
package otp_pkg;
    typedef enum logic [1:0] {
        OP_READ      = 2'd0,
        OP_PROG      = 2'd1,
        OP_LOCK_USER = 2'd2,
        OP_LOCK_SEC  = 2'd3
    } otp_op_e;
endpackage

// File: rtl/otp_cmd_decode.sv
// Command decoder: turns one command into write strobes for the user
// words and the lock bits, and flags a refused program.
// Assumes NUM_WORDS is a power of two and that the upper half is user space,
// so the address MSB selects the user segment.
module otp_cmd_decode
    import otp_pkg::*;
#(
    parameter int NUM_WORDS  = 8,
    localparam int ADDR_W    = $clog2(NUM_WORDS),
    localparam int USER_WDS  = NUM_WORDS / 2
) (
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic                user_locked,
    output logic [USER_WDS-1:0] user_wr,
    output logic                set_user_lock,
    output logic                set_sec_lock,
    output logic                refuse
);
    logic is_user;
    logic is_prog;

    assign is_user = cmd_addr[ADDR_W-1];
    assign is_prog = cmd_valid && (otp_op_e'(cmd_op) == OP_PROG);

    // Write strobe per user word: only when unlocked and addressed.
    always_comb begin
        user_wr = '0;
        if (is_prog && is_user && !user_locked)
            user_wr[cmd_addr[ADDR_W-2:0]] = 1'b1;
    end

    // Program refusal: factory word or frozen user segment.
    assign refuse        = is_prog && (!is_user || user_locked);
    assign set_user_lock = cmd_valid && (otp_op_e'(cmd_op) == OP_LOCK_USER);
    assign set_sec_lock  = cmd_valid && (otp_op_e'(cmd_op) == OP_LOCK_SEC);
endmodule

// File: rtl/otp_word_store.sv
// Word storage: factory words reloaded from a parameter on reset, user words
// that start erased, ignore reset, and only clear bits when programmed.
// Assumes the decoder never strobes more than one user word at a time.
module otp_word_store #(
    parameter int                       WORD_W     = 16,
    parameter int                       NUM_WORDS  = 8,
    parameter logic [WORD_W*NUM_WORDS-1:0] FACTORY_ID = '0,
    localparam int                      FACT_WDS   = NUM_WORDS / 2,
    localparam int                      USER_WDS   = NUM_WORDS - FACT_WDS
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [USER_WDS-1:0]                user_wr,
    input  logic [WORD_W-1:0]                  wdata,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]   words
);
    genvar g;

    // Factory words: constant after reset.
    for (g = 0; g < FACT_WDS; g++) begin : g_fact
        logic [WORD_W-1:0] fact_q;
        // Reload the identifier slice on reset, hold otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)
                fact_q <= FACTORY_ID[g*WORD_W +: WORD_W];
        end
        assign words[g] = fact_q;
    end

    // User words: erased at power-up, untouched by reset.
    for (g = 0; g < USER_WDS; g++) begin : g_user
        logic [WORD_W-1:0] cell_q = '1;
        // AND the program data in, so bits only fall.
        always_ff @(posedge clk) begin
            if (user_wr[g])
                cell_q <= cell_q & wdata;
        end
        assign words[FACT_WDS + g] = cell_q;
    end
endmodule

// File: rtl/otp_lock_bits.sv
// Permanent lock bits: stored active-low like any programmable cell (erased =
// unlocked), cleared once and never set back, not affected by reset.
module otp_lock_bits (
    input  logic clk,
    input  logic set_user_lock,
    input  logic set_sec_lock,
    output logic user_locked,
    output logic sec_locked
);
    logic user_open_q = 1'b1;
    logic sec_open_q  = 1'b1;

    // Program a lock cell from 1 to 0; no path ever raises it again.
    always_ff @(posedge clk) begin
        if (set_user_lock) user_open_q <= 1'b0;
        if (set_sec_lock)  sec_open_q  <= 1'b0;
    end

    assign user_locked = !user_open_q;
    assign sec_locked  = !sec_open_q;
endmodule

// File: rtl/otp_prot_reg.sv
// Top: 128-bit protection register with a factory half, a one-time user half,
// and two permanent locks. Commands complete one cycle after acceptance.
// Assumes one command per cycle at most; reset is synchronous, active low.
module otp_prot_reg
    import otp_pkg::*;
#(
    parameter int    WORD_W     = 16,
    parameter int    NUM_WORDS  = 8,
    parameter int    BLK_IDX_W  = 7,
    parameter logic [WORD_W*NUM_WORDS-1:0] FACTORY_ID =
        128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
    localparam int   ADDR_W     = $clog2(NUM_WORDS),
    localparam int   USER_WDS   = NUM_WORDS / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [WORD_W-1:0]    cmd_wdata,
    input  logic [BLK_IDX_W-1:0] query_blk,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 op_done,
    output logic                 op_err,
    output logic                 user_locked,
    output logic                 sec_locked,
    output logic                 blk_prot
);
    logic [USER_WDS-1:0]               user_wr;
    logic                              set_user_lock;
    logic                              set_sec_lock;
    logic                              refuse;
    logic [NUM_WORDS-1:0][WORD_W-1:0]  words;

    otp_cmd_decode #(.NUM_WORDS(NUM_WORDS)) u_dec (
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_addr     (cmd_addr),
        .user_locked  (user_locked),
        .user_wr      (user_wr),
        .set_user_lock(set_user_lock),
        .set_sec_lock (set_sec_lock),
        .refuse       (refuse)
    );

    otp_word_store #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .FACTORY_ID(FACTORY_ID)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .user_wr(user_wr),
        .wdata  (cmd_wdata),
        .words  (words)
    );

    otp_lock_bits u_locks (
        .clk          (clk),
        .set_user_lock(set_user_lock),
        .set_sec_lock (set_sec_lock),
        .user_locked  (user_locked),
        .sec_locked   (sec_locked)
    );

    // Register the completion status and read data of the current command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_done <= 1'b0;
            op_err  <= 1'b0;
            rd_data <= '0;
        end else begin
            op_done <= cmd_valid;
            op_err  <= refuse;
            if (cmd_valid && otp_op_e'(cmd_op) == OP_READ)
                rd_data <= words[cmd_addr];
        end
    end

    // Block-protection answer: the security lock guards block 0 only.
    assign blk_prot = sec_locked && (query_blk == '0);
endmodule

// File: rtl/otp_prot_reg_chk.sv
// Checker: temporal properties of the protection register, bound to the top.
module otp_prot_reg_chk #(
    parameter int ADDR_W    = 3,
    parameter int BLK_IDX_W = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [1:0]           cmd_op,
    input logic [ADDR_W-1:0]    cmd_addr,
    input logic [BLK_IDX_W-1:0] query_blk,
    input logic                 op_done,
    input logic                 op_err,
    input logic                 user_locked,
    input logic                 sec_locked,
    input logic                 blk_prot
);
    assert_done_after_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> op_done);
    assert_no_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !op_done);
    assert_err_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_err |-> op_done);
    assert_factory_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1 && !cmd_addr[ADDR_W-1]) |=> op_err);
    assert_locked_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1 && user_locked) |=> op_err);
    assert_user_lock_sticky_R6: assert property (@(posedge clk)
        user_locked |=> user_locked);
    assert_sec_lock_sticky_R7: assert property (@(posedge clk)
        sec_locked |=> sec_locked);
    assert_lock_cmd_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2) |=> user_locked);
    assert_query_other_blk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (query_blk != '0) |-> !blk_prot);
endmodule

bind otp_prot_reg otp_prot_reg_chk #(.ADDR_W(ADDR_W), .BLK_IDX_W(BLK_IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .query_blk  (query_blk),
    .op_done    (op_done),
    .op_err     (op_err),
    .user_locked(user_locked),
    .sec_locked (sec_locked),
    .blk_prot   (blk_prot)
);

// File: tb/sim_otp_prot_reg.sv
`timescale 1ns/1ps
// Bench: vector table for read/program sequences, then directed lock,
// reset-retention and idle tests.
module sim_otp_prot_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [2:0]  cmd_addr = 3'd0;
    logic [15:0] cmd_wdata = 16'h0;
    logic [6:0]  query_blk = 7'd0;
    logic [15:0] rd_data;
    logic        op_done, op_err, user_locked, sec_locked, blk_prot;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    otp_prot_reg u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .query_blk(query_blk),
        .rd_data(rd_data), .op_done(op_done), .op_err(op_err),
        .user_locked(user_locked), .sec_locked(sec_locked), .blk_prot(blk_prot)
    );

    // Vector: req(4) op(2) addr(3) wdata(16) exp_rd(16) exp_err(1) chk_rd(1)
    localparam int NV = 17;
    localparam logic [42:0] VEC [NV] = '{
        {4'd2, 2'd0, 3'd0, 16'h0000, 16'h3210, 1'b0, 1'b1},  // R2 factory w0
        {4'd2, 2'd0, 3'd3, 16'h0000, 16'hFEDC, 1'b0, 1'b1},  // R2 factory w3
        {4'd2, 2'd0, 3'd4, 16'h0000, 16'hFFFF, 1'b0, 1'b1},  // R2 erased user
        {4'd3, 2'd1, 3'd4, 16'hA5F0, 16'h0000, 1'b0, 1'b0},  // R3 program
        {4'd3, 2'd0, 3'd4, 16'h0000, 16'hA5F0, 1'b0, 1'b1},
        {4'd3, 2'd1, 3'd4, 16'h0FFF, 16'h0000, 1'b0, 1'b0},  // R3 AND in
        {4'd3, 2'd0, 3'd4, 16'h0000, 16'h05F0, 1'b0, 1'b1},
        {4'd3, 2'd1, 3'd4, 16'hFFFF, 16'h0000, 1'b0, 1'b0},  // R3 ones do not return
        {4'd3, 2'd0, 3'd4, 16'h0000, 16'h05F0, 1'b0, 1'b1},
        {4'd4, 2'd1, 3'd1, 16'h0000, 16'h0000, 1'b1, 1'b0},  // R4 factory refused
        {4'd4, 2'd0, 3'd1, 16'h0000, 16'h7654, 1'b0, 1'b1},
        {4'd3, 2'd1, 3'd7, 16'h1234, 16'h0000, 1'b0, 1'b0},  // R3 top word
        {4'd3, 2'd0, 3'd7, 16'h0000, 16'h1234, 1'b0, 1'b1},
        {4'd6, 2'd2, 3'd0, 16'h0000, 16'h0000, 1'b0, 1'b0},  // R6 lock user
        {4'd5, 2'd1, 3'd5, 16'h0000, 16'h0000, 1'b1, 1'b0},  // R5 refused
        {4'd5, 2'd0, 3'd5, 16'h0000, 16'hFFFF, 1'b0, 1'b1},
        {4'd5, 2'd0, 3'd7, 16'h0000, 16'h1234, 1'b0, 1'b1}
    };

    // Record one comparison; print FAIL with actual and expected on mismatch.
    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one command; return on the falling edge where its result is due.
    task automatic issue(input logic [1:0] op, input logic [2:0] addr,
                         input logic [15:0] data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_wdata = data;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", "op_done", {15'h0, op_done}, 16'h0);
        check("R1", "op_err", {15'h0, op_err}, 16'h0);
        check("R1", "rd_data", rd_data, 16'h0);
        check("R1", "locks", {14'h0, user_locked, sec_locked}, 16'h0);
        issue(2'd0, 3'd2, 16'h0);
        check("R1", "factory w2", rd_data, 16'hBA98);

        for (int i = 0; i < NV; i++) begin
            logic [3:0]  rq;
            logic [1:0]  op;
            logic [2:0]  ad;
            logic [15:0] wd, er;
            logic        ee, cr;
            string       tag;
            {rq, op, ad, wd, er, ee, cr} = VEC[i];
            tag = $sformatf("R%0d vec%0d", rq, i);
            issue(op, ad, wd);
            check(tag, "op_done R9", {15'h0, op_done}, 16'h1);
            check(tag, "op_err", {15'h0, op_err}, {15'h0, ee});
            if (cr) check(tag, "rd_data", rd_data, er);
        end
        check("R6", "user_locked", {15'h0, user_locked}, 16'h1);

        // R7 security lock and block query
        query_blk = 7'd0;
        #1 check("R7", "blk_prot before lock", {15'h0, blk_prot}, 16'h0);
        issue(2'd3, 3'd0, 16'h0);
        check("R7", "sec_locked", {15'h0, sec_locked}, 16'h1);
        check("R7", "blk_prot blk0", {15'h0, blk_prot}, 16'h1);
        query_blk = 7'd3;
        #1 check("R7", "blk_prot blk3", {15'h0, blk_prot}, 16'h0);
        query_blk = 7'd0;

        // R10 idle cycles: no done, no change
        repeat (4) @(negedge clk);
        check("R10", "op_done idle", {15'h0, op_done}, 16'h0);
        issue(2'd0, 3'd4, 16'h0);
        check("R10", "w4 after idle", rd_data, 16'h05F0);

        // R8 reset keeps user words and locks
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", "op_done in reset", {15'h0, op_done}, 16'h0);
        rst_n = 1'b1;
        check("R8", "user_locked kept", {15'h0, user_locked}, 16'h1);
        check("R8", "sec_locked kept", {15'h0, sec_locked}, 16'h1);
        issue(2'd0, 3'd4, 16'h0);
        check("R8", "w4 kept", rd_data, 16'h05F0);
        issue(2'd0, 3'd7, 16'h0);
        check("R8", "w7 kept", rd_data, 16'h1234);
        issue(2'd0, 3'd0, 16'h0);
        check("R1", "factory w0 after reset", rd_data, 16'h3210);

        // R6 lock command again: stays locked, no error
        issue(2'd2, 3'd0, 16'h0);
        check("R6", "relock err", {15'h0, op_err}, 16'h0);
        check("R6", "still locked", {15'h0, user_locked}, 16'h1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule